// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over the one shared data wire of a contact smart card. The wire is open-drain: the block pulls it low through `io_oe` and reads the level back through `io_in`, and an external pull-up holds it high at all other times. On the transmit side a byte is accepted through a valid/ready handshake and sent as one framed character. On the receive side the parity of every character from the card is checked.

The `mode_t1` input selects the protocol. With `mode_t1` low (T=0), each character is acknowledged on the wire itself. The receiver rejects a character with bad parity by pulling the wire low for one elementary time unit (ETU). The transmitter watches for that pulse after each character and resends the byte until a programmable retry budget runs out. With `mode_t1` high (T=1), neither the rejection pulse nor the resend happens.

The block is half-duplex. It never transmits while a reception is in progress, and its receiver ignores the wire while the transmitter owns it. All timing comes from one ETU counter with a parameterised length, 372 clock cycles by default.

Top module: `sc_char_xcvr`

## Requirements
- R1: After reset `io_oe` is 0, `tx_ready` is 1, `rx_valid` is 0, and both `tx_error` and `rx_parity_err` are 0.
- R2: A transmitted character occupies ten bit slots of ETU_CYCLES clocks each. Slot 0 is the start bit (wire low, `io_oe`=1), slots 1 to 8 carry data bits 0 to 7 with the least significant bit first, and slot 9 is the parity bit. A bit value of 1 means the wire is released.
- R3: The parity bit makes the number of ones over the eight data bits plus the parity bit even.
- R4: `io_oe` returns to 0 when the parity slot ends and stays 0 through the following two ETU. It is 0 whenever `tx_ready` is 1.
- R5: A received character with even parity produces one single-cycle `rx_valid` pulse with the byte on `rx_data`, and the block does not drive the wire afterwards.
- R6: A low level on the wire that has ended before the middle of the start-bit ETU is rejected: no character, no flag and no wire drive result from it.
- R7: In T=0 mode, a received character with odd parity drives `io_oe`=1 for exactly ETU_CYCLES clocks. The pulse starts about half an ETU after the middle of the parity bit. No `rx_valid` is given for that character.
- R8: In T=1 mode, a received character with odd parity never drives the wire.
- R9: `rx_parity_err` is set by any odd-parity character, in both modes, and stays set until reset.
- R10: In T=0 mode, if the wire is low at the middle of the ETU that follows the parity slot, the same byte is sent again. The new start bit begins exactly 12 ETU after the previous one.
- R11: After `retry_max` resends have all been rejected, the character is dropped, `tx_error` is set, and `tx_ready` returns. `tx_error` stays set until reset.
- R12: In T=1 mode, a low wire after the parity slot causes no resend and no `tx_error`.
- R13: The start bits of two characters accepted one after the other lie at least 12 ETU apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_t1 | input | 1 | 0 selects T=0 (error signalling and resend), 1 selects T=1 |
| retry_max | input | RETRY_W | Number of resends allowed per character in T=0 |
| tx_valid | input | 1 | A byte to send is present on tx_data |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | The block can accept a byte in this cycle |
| rx_valid | output | 1 | Single-cycle pulse: rx_data holds a good character |
| rx_data | output | 8 | Last byte received with good parity |
| rx_parity_err | output | 1 | Sticky: a character with bad parity was received |
| tx_error | output | 1 | Sticky: a character was dropped after exhausting its retries |
| io_in | input | 1 | Level read back from the card wire |
| io_oe | output | 1 | 1 pulls the card wire low; 0 releases it to the pull-up |

## Verification
The properties assume that `mode_t1` only changes while the block is idle. If it changed during a reception, a rejection pulse could already be running when T=1 takes effect. They also assume that the card never starts a character while the block is transmitting or within the guard slots that follow. The bench switches modes and applies resets only after every transfer has finished. The card model drives the wire only in its own transfers or in the rejection window after a character from the block, so these conditions always hold.

// File: rtl/sc_xcvr_pkg.sv
`timescale 1ns/1ps
package sc_xcvr_pkg;

  localparam int CHAR_BITS  = 8;
  localparam int FRAME_BITS = CHAR_BITS + 2;   // start + data + parity
  localparam int SLOT_COUNT = FRAME_BITS + 2;  // plus nak window and guard
  localparam int SLOT_W     = $clog2(SLOT_COUNT);

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_BITS,
    TX_WATCH
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_TAIL,
    RX_FLAG
  } rx_state_e;

  // parity bit that makes data plus parity an even count of ones
  function automatic logic even_fill(input logic [CHAR_BITS-1:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/sc_line_sync.sv
`timescale 1ns/1ps
module sc_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= {STAGES{RESET_VAL}};
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];

endmodule

// File: rtl/sc_etu_count.sv
`timescale 1ns/1ps
module sc_etu_count #(
  parameter int ETU_CYCLES = 372
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic at_half,
  output logic at_end
);

  localparam int HALF  = ETU_CYCLES / 2;
  localparam int CNT_W = $clog2(ETU_CYCLES);

  logic [CNT_W-1:0] cnt;

  assign at_half = (cnt == CNT_W'(HALF - 1));
  assign at_end  = (cnt == CNT_W'(ETU_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (at_end)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sc_tx_engine.sv
`timescale 1ns/1ps
module sc_tx_engine
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_CYCLES = 372,
  parameter int RETRY_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_t1,
  input  logic [RETRY_W-1:0]   retry_max,
  input  logic                 req_valid,
  input  logic [CHAR_BITS-1:0] req_data,
  output logic                 req_ready,
  input  logic                 line_s,
  input  logic                 rx_busy,
  output logic                 busy,
  output logic                 drv,
  output logic                 fail
);

  localparam logic [SLOT_W-1:0] LAST_BIT  = SLOT_W'(FRAME_BITS - 1);
  localparam logic [SLOT_W-1:0] NAK_SLOT  = SLOT_W'(FRAME_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_COUNT - 1);

  tx_state_e              st;
  logic [CHAR_BITS-1:0]   hold;
  logic [FRAME_BITS-1:0]  sh;
  logic [SLOT_W-1:0]      slot;
  logic [RETRY_W-1:0]     tries;
  logic                   nak;
  logic                   at_half, at_end;
  logic                   accept;

  assign req_ready = (st == TX_IDLE) && !rx_busy;
  assign accept    = req_ready && req_valid;
  assign busy      = (st != TX_IDLE);

  sc_etu_count #(.ETU_CYCLES(ETU_CYCLES)) u_etu (
    .clk     (clk),
    .rst     (rst),
    .clear   (st == TX_IDLE),
    .at_half (at_half),
    .at_end  (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TX_IDLE;
      hold  <= '0;
      sh    <= '0;
      slot  <= '0;
      tries <= '0;
      nak   <= 1'b0;
      drv   <= 1'b0;
      fail  <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (accept) begin
            hold  <= req_data;
            sh    <= {even_fill(req_data), req_data, 1'b0};
            drv   <= 1'b1;
            slot  <= '0;
            tries <= '0;
            nak   <= 1'b0;
            st    <= TX_BITS;
          end
        end
        TX_BITS: begin
          if (at_end) begin
            slot <= slot + 1'b1;
            if (slot == LAST_BIT) begin
              drv <= 1'b0;
              st  <= TX_WATCH;
            end else begin
              sh  <= sh >> 1;
              drv <= ~sh[1];
            end
          end
        end
        TX_WATCH: begin
          if (slot == NAK_SLOT && at_half && !mode_t1)
            nak <= ~line_s;
          if (at_end) begin
            if (slot != LAST_SLOT) begin
              slot <= slot + 1'b1;
            end else if (!nak) begin
              st <= TX_IDLE;
            end else if (tries == retry_max) begin
              fail <= 1'b1;
              st   <= TX_IDLE;
            end else begin
              tries <= tries + 1'b1;
              sh    <= {even_fill(hold), hold, 1'b0};
              drv   <= 1'b1;
              slot  <= '0;
              nak   <= 1'b0;
              st    <= TX_BITS;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_rx_engine.sv
`timescale 1ns/1ps
module sc_rx_engine
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_CYCLES = 372
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_t1,
  input  logic                 enable,
  input  logic                 line_s,
  output logic                 busy,
  output logic                 drv,
  output logic                 valid,
  output logic [CHAR_BITS-1:0] data,
  output logic                 perr
);

  localparam int BIT_W = $clog2(CHAR_BITS + 1);
  localparam logic [BIT_W-1:0] PAR_IDX = BIT_W'(CHAR_BITS);

  rx_state_e            st;
  logic [BIT_W-1:0]     bidx;
  logic [CHAR_BITS:0]   sh;
  logic [CHAR_BITS:0]   nxt;
  logic                 bad;
  logic                 at_half, at_end;
  logic                 clr;

  assign nxt  = {line_s, sh[CHAR_BITS:1]};
  assign busy = (st != RX_IDLE);
  assign clr  = (st == RX_IDLE) ||
                (st == RX_START && at_half) ||
                (st == RX_TAIL  && at_half);

  sc_etu_count #(.ETU_CYCLES(ETU_CYCLES)) u_etu (
    .clk     (clk),
    .rst     (rst),
    .clear   (clr),
    .at_half (at_half),
    .at_end  (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      bidx  <= '0;
      sh    <= '0;
      bad   <= 1'b0;
      drv   <= 1'b0;
      valid <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (enable && !line_s) st <= RX_START;
        end
        RX_START: begin
          if (at_half) begin
            if (line_s) begin
              st <= RX_IDLE;
            end else begin
              bidx <= '0;
              st   <= RX_DATA;
            end
          end
        end
        RX_DATA: begin
          if (at_end) begin
            sh <= nxt;
            if (bidx == PAR_IDX) begin
              bad <= ^nxt;
              if (^nxt) begin
                perr <= 1'b1;
              end else begin
                valid <= 1'b1;
                data  <= nxt[CHAR_BITS-1:0];
              end
              st <= RX_TAIL;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        RX_TAIL: begin
          if (at_half) begin
            if (bad && !mode_t1) begin
              drv <= 1'b1;
              st  <= RX_FLAG;
            end else begin
              st <= RX_IDLE;
            end
          end
        end
        RX_FLAG: begin
          if (at_end) begin
            drv <= 1'b0;
            st  <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_char_xcvr.sv
`timescale 1ns/1ps
module sc_char_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_CYCLES  = 372,
  parameter int RETRY_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_t1,
  input  logic [RETRY_W-1:0]   retry_max,
  input  logic                 tx_valid,
  input  logic [CHAR_BITS-1:0] tx_data,
  output logic                 tx_ready,
  output logic                 rx_valid,
  output logic [CHAR_BITS-1:0] rx_data,
  output logic                 rx_parity_err,
  output logic                 tx_error,
  input  logic                 io_in,
  output logic                 io_oe
);

  logic line_s;
  logic tx_busy, rx_busy;
  logic tx_oe, rx_oe;

  sc_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (io_in),
    .dout (line_s)
  );

  sc_tx_engine #(.ETU_CYCLES(ETU_CYCLES), .RETRY_W(RETRY_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .mode_t1   (mode_t1),
    .retry_max (retry_max),
    .req_valid (tx_valid),
    .req_data  (tx_data),
    .req_ready (tx_ready),
    .line_s    (line_s),
    .rx_busy   (rx_busy),
    .busy      (tx_busy),
    .drv       (tx_oe),
    .fail      (tx_error)
  );

  sc_rx_engine #(.ETU_CYCLES(ETU_CYCLES)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .mode_t1 (mode_t1),
    .enable  (!tx_busy),
    .line_s  (line_s),
    .busy    (rx_busy),
    .drv     (rx_oe),
    .valid   (rx_valid),
    .data    (rx_data),
    .perr    (rx_parity_err)
  );

  assign io_oe = tx_oe | rx_oe;

endmodule

// File: rtl/sc_char_xcvr_chk.sv
`timescale 1ns/1ps
module sc_char_xcvr_chk #(
  parameter int ETU_CYCLES = 372
) (
  input logic clk,
  input logic rst,
  input logic mode_t1,
  input logic io_oe,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_parity_err,
  input logic tx_error,
  input logic tx_drv,
  input logic rx_drv
);

  localparam int RUN_W = $clog2(ETU_CYCLES + 2) + 1;

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)         run <= '0;
    else if (rx_drv) run <= run + 1'b1;
    else             run <= '0;
  end

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !io_oe);

  assert_one_driver_R4: assert property (@(posedge clk) disable iff (rst)
    !(tx_drv && rx_drv));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_flag_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_drv) |-> (run == RUN_W'(ETU_CYCLES)));

  assert_t1_silent_R8: assert property (@(posedge clk) disable iff (rst)
    mode_t1 |-> !rx_drv);

  assert_perr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    rx_parity_err |=> rx_parity_err);

  assert_txerr_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    tx_error |=> tx_error);

endmodule

bind sc_char_xcvr sc_char_xcvr_chk #(.ETU_CYCLES(ETU_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_t1       (mode_t1),
  .io_oe         (io_oe),
  .tx_ready      (tx_ready),
  .rx_valid      (rx_valid),
  .rx_parity_err (rx_parity_err),
  .tx_error      (tx_error),
  .tx_drv        (tx_oe),
  .rx_drv        (rx_oe)
);

// File: tb/sc_char_xcvr_bench.sv
`timescale 1ns/1ps
module sc_char_xcvr_bench;

  localparam int PERIOD = 4;
  localparam int E      = 16;
  localparam int RW     = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_t1 = 1'b0;
  logic [RW-1:0] retry_max = 3'd1;
  logic          tx_valid = 1'b0;
  logic [7:0]    tx_data = 8'h00;
  logic          tx_ready, rx_valid, rx_parity_err, tx_error, io_oe;
  logic [7:0]    rx_data;
  logic          card_oe = 1'b0;
  logic          io_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;
  assign io_in = !(io_oe || card_oe);

  sc_char_xcvr #(.ETU_CYCLES(E), .RETRY_W(RW)) u_sc_char_xcvr (
    .clk (clk), .rst (rst), .mode_t1 (mode_t1), .retry_max (retry_max),
    .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
    .rx_valid (rx_valid), .rx_data (rx_data), .rx_parity_err (rx_parity_err),
    .tx_error (tx_error), .io_in (io_in), .io_oe (io_oe)
  );

  // received-character capture
  int         rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  always @(posedge clk) if (rx_valid) begin rx_cnt++; rx_last = rx_data; end

  // card-side monitor of frames sent by the block, with optional rejection
  bit         mon_en = 0;
  int         inj_left = 0;
  int         mon_n = 0;
  logic [7:0] mon_byte [0:7];
  logic       mon_par  [0:7];
  logic       mon_start[0:7];
  time        mon_t    [0:7];

  initial forever begin
    logic [9:0] b;
    time t0;
    @(posedge io_oe);
    if (mon_en) begin
      t0 = $time;
      repeat (E/2) @(posedge clk);
      #1 b[0] = ~io_oe;
      for (int i = 1; i < 10; i++) begin
        repeat (E) @(posedge clk);
        #1 b[i] = ~io_oe;
      end
      if (mon_n < 8) begin
        mon_start[mon_n] = b[0];
        mon_byte[mon_n]  = b[8:1];
        mon_par[mon_n]   = b[9];
        mon_t[mon_n]     = t0;
      end
      mon_n++;
      repeat (E/2) @(posedge clk);
      #1;
      if (inj_left > 0) begin
        inj_left--;
        card_oe = 1'b1;
        repeat (E) @(posedge clk);
        #1 card_oe = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic tx_send(input logic [7:0] d);
    @(posedge clk); #1 tx_valid = 1'b1; tx_data = d;
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  // card sends one character; reports io_oe mid rejection window and after it
  task automatic card_send(input logic [7:0] d, input bit flip,
                           output logic oe_mid, output logic oe_after);
    logic [9:0] f;
    f = {(^d) ^ flip, d, 1'b0};
    @(posedge clk); #1;
    for (int i = 0; i < 10; i++) begin
      card_oe = ~f[i];
      repeat (E) @(posedge clk);
      #1;
    end
    card_oe = 1'b0;
    repeat (E/2) @(posedge clk);
    #1 oe_mid = io_oe;
    repeat (E + E/2) @(posedge clk);
    #1 oe_after = io_oe;
    repeat (2*E) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 io_oe", int'(io_oe), 0);
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 tx_error", int'(tx_error), 0);
    chk("R1 rx_parity_err", int'(rx_parity_err), 0);
  endtask

  task automatic t_rx_good();
    logic m, a; int c0;
    c0 = rx_cnt;
    card_send(8'h3C, 1'b0, m, a);
    chk("R5 count", rx_cnt - c0, 1);
    chk("R5 data", int'(rx_last), 'h3C);
    chk("R5 no drive", int'(m), 0);
    chk("R5 perr clear", int'(rx_parity_err), 0);
  endtask

  task automatic t_glitch();
    logic m, a; int c0;
    c0 = rx_cnt;
    @(posedge clk); #1 card_oe = 1'b1;
    repeat (3) @(posedge clk);
    #1 card_oe = 1'b0;
    repeat (2*E) @(posedge clk);
    #1;
    chk("R6 no char", rx_cnt - c0, 0);
    chk("R6 no drive", int'(io_oe), 0);
    chk("R6 no flag", int'(rx_parity_err), 0);
    card_send(8'h81, 1'b0, m, a);
    chk("R6 next char data", int'(rx_last), 'h81);
    chk("R6 next char count", rx_cnt - c0, 1);
  endtask

  task automatic t_rx_bad_t0();
    logic m, a; int c0;
    c0 = rx_cnt;
    card_send(8'h5A, 1'b1, m, a);
    chk("R7 pulse present", int'(m), 1);
    chk("R7 pulse ended", int'(a), 0);
    chk("R7 no rx_valid", rx_cnt - c0, 0);
    chk("R9 flag T0", int'(rx_parity_err), 1);
  endtask

  task automatic t_rx_bad_t1();
    logic m, a; int c0;
    do_reset();
    mode_t1 = 1'b1;
    c0 = rx_cnt;
    card_send(8'h5A, 1'b1, m, a);
    chk("R8 no pulse mid", int'(m), 0);
    chk("R8 no pulse after", int'(a), 0);
    chk("R9 flag T1", int'(rx_parity_err), 1);
    chk("R9 no rx_valid", rx_cnt - c0, 0);
    mode_t1 = 1'b0;
    do_reset();
  endtask

  task automatic t_tx_basic();
    mon_en = 1; mon_n = 0; inj_left = 0;
    tx_send(8'hA5);
    repeat (10*E + E/2) @(posedge clk);
    #1;
    chk("R4 released after parity", int'(io_oe), 0);
    chk("R13 guard busy", int'(tx_ready), 0);
    repeat (2*E) @(posedge clk);
    #1;
    chk("R4 ready after guard", int'(tx_ready), 1);
    chk("R2 frame count", mon_n, 1);
    chk("R2 start bit", int'(mon_start[0]), 0);
    chk("R2 data", int'(mon_byte[0]), 'hA5);
    chk("R3 parity A5", int'(mon_par[0]), 0);
    tx_send(8'h01);
    repeat (13*E) @(posedge clk);
    #1;
    chk("R2 data 01", int'(mon_byte[1]), 'h01);
    chk("R3 parity 01", int'(mon_par[1]), 1);
    mon_en = 0;
  endtask

  task automatic t_tx_retry();
    mon_en = 1; mon_n = 0; inj_left = 1; retry_max = 3'd1;
    tx_send(8'h3C);
    repeat (26*E) @(posedge clk);
    #1;
    chk("R10 frames", mon_n, 2);
    chk("R10 same byte", int'(mon_byte[1]), 'h3C);
    chk("R10 spacing", int'((mon_t[1] - mon_t[0]) / PERIOD), 12*E);
    chk("R10 no error", int'(tx_error), 0);
    mon_en = 0;
  endtask

  task automatic t_tx_limit();
    mon_en = 1; mon_n = 0; inj_left = 5; retry_max = 3'd2;
    tx_send(8'hC3);
    repeat (38*E) @(posedge clk);
    #1;
    chk("R11 frames", mon_n, 3);
    chk("R11 rejections used", inj_left, 2);
    chk("R11 tx_error", int'(tx_error), 1);
    chk("R11 ready again", int'(tx_ready), 1);
    inj_left = 0; mon_n = 0;
    tx_send(8'h42);
    repeat (13*E) @(posedge clk);
    #1;
    chk("R11 sticky", int'(tx_error), 1);
    chk("R11 next frame", mon_n, 1);
    mon_en = 0;
    do_reset();
  endtask

  task automatic t_tx_t1();
    mode_t1 = 1'b1;
    mon_en = 1; mon_n = 0; inj_left = 1; retry_max = 3'd1;
    tx_send(8'h77);
    repeat (26*E) @(posedge clk);
    #1;
    chk("R12 single frame", mon_n, 1);
    chk("R12 pulse seen by card", inj_left, 0);
    chk("R12 no error", int'(tx_error), 0);
    mon_en = 0; mode_t1 = 1'b0;
  endtask

  task automatic t_guard();
    mon_en = 1; mon_n = 0; inj_left = 0;
    tx_send(8'h11);
    tx_send(8'h22);
    repeat (14*E) @(posedge clk);
    #1;
    chk("R13 frames", mon_n, 2);
    chk("R13 gap ok", int'(((mon_t[1] - mon_t[0]) / PERIOD) >= 12*E), 1);
    chk("R13 second byte", int'(mon_byte[1]), 'h22);
    mon_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_rx_good();
    t_glitch();
    t_rx_bad_t0();
    t_rx_bad_t1();
    t_tx_basic();
    t_tx_retry();
    t_tx_limit();
    t_tx_t1();
    t_guard();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule